// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block carries an 18-bit word between two buses, called A and B, in either direction. Each direction has its own storage word and its own three controls: an output enable, a latch enable and a transfer clock. With the latch enable high, the storage follows the source bus (pass mode). With the latch enable low, the storage keeps its contents until the transfer clock rises, and then it captures the source bus (capture mode). With the latch enable low and no rising edge, the contents are held. Each stored word drives the opposite bus through a tri-state driver that the direction's output enable controls.

The block is a functional cycle model. It runs on one system clock. The transfer clocks and the latch enables are sampled on that clock, and a rising edge of a transfer clock is a low sample followed by a high sample. Each bus is split into the resolved wire value (input), a per-bit flag that says whether anything outside drives that bit (input), the value to drive (output) and a driver enable (output). The wire itself is resolved outside the block.

When the `HOLD_EN` parameter is set, each input bit has a keeper. A bit that nobody drives reads as the last value it carried while it was driven, so the bit never floats.

Top module: `dual_path_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both stored words clear to zero and both driver enables (`a_oe_o`, `b_oe_o`) are low. These values are visible one clock after reset is sampled low.
- R2: If `ab_le_i` is sampled high, `b_out_o` equals the resolved A input sampled at that same edge, one clock later.
- R3: If `ab_le_i` is sampled low and `ab_clk_i` shows no rise (a low sample followed by a high sample), `b_out_o` does not change, whatever the A bus does.
- R4: If `ab_le_i` is sampled low at the edge where `ab_clk_i` is first sampled high after a low sample, the A input is captured, and `b_out_o` shows it one clock later. A falling transfer clock captures nothing.
- R5: When `ab_le_i` goes from high to low with no clock rise, the stored word keeps the value sampled at the last edge where the latch enable was high.
- R6: `b_oe_o` follows `ab_oe_i`, and `a_oe_o` follows `ba_oe_i`, each one clock later. The environment must never assert both enables together, because that is bus contention.
- R7: The B-to-A path behaves like the A-to-B path, using `ba_le_i`, `ba_clk_i` and `b_in_i`, and it drives `a_out_o`. Neither path's controls affect the other path's stored word.
- R8: All W bits share the controls of their direction, and every bit carries its own data value.
- R9: With `HOLD_EN`=1, an input bit whose drive flag (`a_drv_i`/`b_drv_i`) is 0 resolves to the last value it had while its flag was 1 (0 after reset). Bits that are driven resolve to the input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable (1 = pass) |
| ab_clk_i | input | 1 | A-to-B transfer clock |
| ba_oe_i | input | 1 | B-to-A output enable, active high |
| ba_le_i | input | 1 | B-to-A latch enable (1 = pass) |
| ba_clk_i | input | 1 | B-to-A transfer clock |
| a_in_i | input | W | Resolved value on the A wire |
| a_drv_i | input | W | Per-bit flag: an external driver is active on A |
| a_out_o | output | W | Stored B-to-A word to drive onto A |
| a_oe_o | output | 1 | A driver enable (0 = high impedance) |
| b_in_i | input | W | Resolved value on the B wire |
| b_drv_i | input | W | Per-bit flag: an external driver is active on B |
| b_out_o | output | W | Stored A-to-B word to drive onto B |
| b_oe_o | output | 1 | B driver enable (0 = high impedance) |

## Verification
Every result of this block is due exactly one system clock after the edge that samples its cause. This covers a pass-mode copy, a capture on a transfer-clock rise, a change of driver enable, a keeper update and the reset clear. The bench changes inputs 1 ns after a rising edge. It then waits for the next rising edge and checks 1 ns after it, so each check reads the state that follows one sampling edge. Hold and freeze cases are checked after several idle edges, which shows that nothing moved during the whole wait.

// File: rtl/xcvr_pkg.sv
// Package: shared types and helpers for the dual-direction transceiver.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package xcvr_pkg;

    // Update action of one direction's storage word.
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } store_mode_e;

    // Select the storage action from the latch enable and the clock-rise flag.
    function automatic store_mode_e pick_mode(input logic le, input logic rise);
        if (le)        return MODE_PASS;
        else if (rise) return MODE_CAPTURE;
        else           return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge_detect.sv
// Module: xcvr_edge_detect
// Detects a rising edge of a slow control clock that is sampled on the
// system clock. Assumes the control clock is already synchronous to clk.
// The history flop follows the input even during reset, so a clock held
// high through reset release is not taken for an edge.
module xcvr_edge_detect (
    input  logic clk,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the level sampled at the previous system edge.
    always_ff @(posedge clk) begin
        prev_q <= sig_i;
    end

    // A rise is a high sample that follows a low one.
    always_comb begin
        rise_o = sig_i & ~prev_q;
    end
endmodule

// File: rtl/xcvr_bus_keeper.sv
// Module: xcvr_bus_keeper
// Resolves each input bit. With HOLD_EN=1, a bit whose external-drive flag
// is low reads as the last value seen while it was driven (the keeper
// clears to 0 on reset). With HOLD_EN=0, the raw wire value is used.
// Assumes drive flags and data come from the same sampling instant.
module xcvr_bus_keeper #(
    parameter int W       = 18,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wire_i,
    input  logic [W-1:0] drv_i,
    output logic [W-1:0] res_o
);
    generate
        if (HOLD_EN) begin : g_hold
            logic [W-1:0] keep_q;
            for (genvar i = 0; i < W; i++) begin : g_bit
                // Per-bit keeper: reload whenever the bit is driven.
                always_ff @(posedge clk) begin
                    if (!rst_n)        keep_q[i] <= 1'b0;
                    else if (drv_i[i]) keep_q[i] <= wire_i[i];
                end
                // Driven bits pass; undriven bits read the keeper.
                always_comb begin
                    res_o[i] = drv_i[i] ? wire_i[i] : keep_q[i];
                end
            end
        end else begin : g_raw
            // No keeper: the wire value is taken as is.
            always_comb begin
                res_o = wire_i;
            end
        end
    endgenerate
endmodule

// File: rtl/xcvr_dir_path.sv
// Module: xcvr_dir_path
// One transfer direction: input resolution, clock-edge detection, the
// pass/capture/hold storage word and the registered driver enable.
// Assumes all control inputs are synchronous to clk. Every output changes
// one system clock after the sampling edge.
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W       = 18,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_i,
    input  logic         le_i,
    input  logic         xclk_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] src_drv_i,
    output logic [W-1:0] dst_o,
    output logic         dst_oe_o
);
    logic [W-1:0] src_res;
    logic         xclk_rise;
    store_mode_e  mode;
    logic [W-1:0] store_q;
    logic         oe_q;

    xcvr_bus_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep (
        .clk    (clk),
        .rst_n  (rst_n),
        .wire_i (src_i),
        .drv_i  (src_drv_i),
        .res_o  (src_res)
    );

    xcvr_edge_detect u_edge (
        .clk    (clk),
        .sig_i  (xclk_i),
        .rise_o (xclk_rise)
    );

    // Choose this cycle's storage action.
    always_comb begin
        mode = pick_mode(le_i, xclk_rise);
    end

    // Storage word: follow, capture or hold the resolved source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                MODE_PASS:    store_q <= src_res;
                MODE_CAPTURE: store_q <= src_res;
                default:      store_q <= store_q;
            endcase
        end
    end

    // Driver enable: registered, forced off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_i;
    end

    // Drive the destination port from the storage word.
    always_comb begin
        dst_o    = store_q;
        dst_oe_o = oe_q;
    end
endmodule

// File: rtl/dual_path_bus_xcvr.sv
// Module: dual_path_bus_xcvr (top)
// W-bit transceiver between bus A and bus B. It has two independent
// direction paths, each with its own enable, latch enable and transfer clock.
// Assumes the bus wires are resolved outside and the environment never
// enables both drivers together.
module dual_path_bus_xcvr #(
    parameter int W       = 18,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe_i,
    input  logic         ab_le_i,
    input  logic         ab_clk_i,
    input  logic         ba_oe_i,
    input  logic         ba_le_i,
    input  logic         ba_clk_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] a_drv_i,
    output logic [W-1:0] a_out_o,
    output logic         a_oe_o,
    input  logic [W-1:0] b_in_i,
    input  logic [W-1:0] b_drv_i,
    output logic [W-1:0] b_out_o,
    output logic         b_oe_o
);
    // A-to-B path: sources from A, drives B.
    xcvr_dir_path #(.W(W), .HOLD_EN(HOLD_EN)) u_ab (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_i      (ab_oe_i),
        .le_i      (ab_le_i),
        .xclk_i    (ab_clk_i),
        .src_i     (a_in_i),
        .src_drv_i (a_drv_i),
        .dst_o     (b_out_o),
        .dst_oe_o  (b_oe_o)
    );

    // B-to-A path: sources from B, drives A.
    xcvr_dir_path #(.W(W), .HOLD_EN(HOLD_EN)) u_ba (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_i      (ba_oe_i),
        .le_i      (ba_le_i),
        .xclk_i    (ba_clk_i),
        .src_i     (b_in_i),
        .src_drv_i (b_drv_i),
        .dst_o     (a_out_o),
        .dst_oe_o  (a_oe_o)
    );
endmodule

// File: rtl/xcvr_checker.sv
// Module: xcvr_checker
// Concurrent assertions on the transceiver ports, bound to the top module.
// Assumes one-clock result latency.
module xcvr_checker #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe_i,
    input  logic         ab_le_i,
    input  logic         ab_clk_i,
    input  logic         ba_oe_i,
    input  logic         ba_le_i,
    input  logic         ba_clk_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] a_drv_i,
    input  logic [W-1:0] a_out_o,
    input  logic         a_oe_o,
    input  logic [W-1:0] b_in_i,
    input  logic [W-1:0] b_drv_i,
    input  logic [W-1:0] b_out_o,
    input  logic         b_oe_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (b_out_o == '0 && a_out_o == '0 && !a_oe_o && !b_oe_o));

    assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le_i && (&a_drv_i)) |=> (b_out_o == $past(a_in_i)));

    assert_ab_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_i && !(ab_clk_i && !$past(ab_clk_i))) |=> $stable(b_out_o));

    assert_ab_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_i && ab_clk_i && !$past(ab_clk_i) && (&a_drv_i))
        |=> (b_out_o == $past(a_in_i)));

    assert_b_oe_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (b_oe_o == $past(ab_oe_i)));

    assert_oe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ab_oe_i && ba_oe_i));

    assert_ba_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le_i && (&b_drv_i)) |=> (a_out_o == $past(b_in_i)));

    assert_ba_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le_i && !(ba_clk_i && !$past(ba_clk_i))) |=> $stable(a_out_o));

    assert_a_oe_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a_oe_o == $past(ba_oe_i)));
endmodule

bind dual_path_bus_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab_oe_i  (ab_oe_i),
    .ab_le_i  (ab_le_i),
    .ab_clk_i (ab_clk_i),
    .ba_oe_i  (ba_oe_i),
    .ba_le_i  (ba_le_i),
    .ba_clk_i (ba_clk_i),
    .a_in_i   (a_in_i),
    .a_drv_i  (a_drv_i),
    .a_out_o  (a_out_o),
    .a_oe_o   (a_oe_o),
    .b_in_i   (b_in_i),
    .b_drv_i  (b_drv_i),
    .b_out_o  (b_out_o),
    .b_oe_o   (b_oe_o)
);

// File: tb/sim_dual_path_bus_xcvr.sv
module sim_dual_path_bus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_oe_i = 1'b0, ab_le_i = 1'b0, ab_clk_i = 1'b0;
    logic         ba_oe_i = 1'b0, ba_le_i = 1'b0, ba_clk_i = 1'b0;
    logic [W-1:0] a_in_i = '0, a_drv_i = '1, b_in_i = '0, b_drv_i = '1;
    logic [W-1:0] a_out_o, b_out_o;
    logic         a_oe_o, b_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dual_path_bus_xcvr #(.W(W), .HOLD_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i),
        .ba_oe_i(ba_oe_i), .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i),
        .a_in_i(a_in_i), .a_drv_i(a_drv_i), .a_out_o(a_out_o), .a_oe_o(a_oe_o),
        .b_in_i(b_in_i), .b_drv_i(b_drv_i), .b_out_o(b_out_o), .b_oe_o(b_oe_o)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    // Advance one edge; return 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ab_le_i = 1'b1; ba_le_i = 1'b1; ab_oe_i = 1'b1;
        a_in_i = 18'h3FFFF; b_in_i = 18'h2AAAA;
        tick(); tick();
        check("R1 b_out", b_out_o, '0);
        check("R1 a_out", a_out_o, '0);
        check("R1 oe", {16'd0, a_oe_o, b_oe_o}, '0);
        ab_oe_i = 1'b0; ab_le_i = 1'b0; ba_le_i = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_pass();
        ab_le_i = 1'b1; a_in_i = 18'h2A5C3;
        tick();
        check("R2 pass1", b_out_o, 18'h2A5C3);
        a_in_i = 18'h15A3C;
        tick();
        check("R8 pass2 per-bit", b_out_o, 18'h15A3C);
    endtask

    task automatic t_freeze();
        a_in_i = 18'h0F0F1;
        tick();
        ab_le_i = 1'b0; a_in_i = 18'h30303;
        tick(); tick(); tick();
        check("R5 freeze", b_out_o, 18'h0F0F1);
    endtask

    task automatic t_clock();
        a_in_i = 18'h11111; tick(); a_in_i = 18'h22222; tick();
        check("R3 hold clk low", b_out_o, 18'h0F0F1);
        ab_clk_i = 1'b1; a_in_i = 18'h3C3C3;
        tick();
        check("R4 capture on rise", b_out_o, 18'h3C3C3);
        a_in_i = 18'h01234;
        tick(); tick();
        check("R3 hold clk high", b_out_o, 18'h3C3C3);
        ab_clk_i = 1'b0; a_in_i = 18'h2FEDC;
        tick();
        check("R4 no capture on fall", b_out_o, 18'h3C3C3);
        ab_clk_i = 1'b1;
        tick();
        check("R4 second rise", b_out_o, 18'h2FEDC);
        ab_clk_i = 1'b0;
        tick();
    endtask

    task automatic t_oe();
        ab_oe_i = 1'b1;
        tick();
        check("R6 b_oe on", {17'd0, b_oe_o}, 18'd1);
        check("R6 a_oe off", {17'd0, a_oe_o}, 18'd0);
        ab_oe_i = 1'b0;
        tick();
        check("R6 b_oe off", {17'd0, b_oe_o}, 18'd0);
        ba_oe_i = 1'b1;
        tick();
        check("R6 a_oe on", {17'd0, a_oe_o}, 18'd1);
        ba_oe_i = 1'b0;
        tick();
    endtask

    task automatic t_ba();
        ba_le_i = 1'b1; b_in_i = 18'h1B6D9;
        tick();
        check("R7 ba pass", a_out_o, 18'h1B6D9);
        check("R7 ab untouched", b_out_o, 18'h2FEDC);
        ba_le_i = 1'b0; b_in_i = 18'h00FF0;
        tick();
        check("R7 ba freeze", a_out_o, 18'h1B6D9);
        ba_clk_i = 1'b1;
        tick();
        check("R7 ba capture", a_out_o, 18'h00FF0);
        check("R7 ab still untouched", b_out_o, 18'h2FEDC);
        ba_clk_i = 1'b0;
        tick();
    endtask

    task automatic t_bushold();
        logic [W-1:0] m, exp;
        ab_le_i = 1'b1; a_drv_i = '1; a_in_i = 18'h2D2D2;
        tick();
        m = 18'h001FF;  // low nine bits undriven
        a_drv_i = ~m; a_in_i = ~18'h2D2D2;
        exp = (18'h2D2D2 & m) | (~18'h2D2D2 & ~m);
        tick();
        check("R9 partial keep", b_out_o, exp);
        a_drv_i = '0; a_in_i = 18'h15555;
        tick(); tick();
        check("R9 all undriven", b_out_o, exp);
        a_drv_i = '1; ab_le_i = 1'b0;
        tick();
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_pass();
        t_freeze();
        t_clock();
        t_oe();
        t_ba();
        t_bushold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule